// File: doc/BRIEF.md
# PHY Interrupt Event Controller

This block holds the interrupt control register and the interrupt status/enable register of an Ethernet PHY. Event sources inside the PHY raise single-cycle pulses: link quality, energy detect, link change, speed change, duplex change, auto-negotiation complete, two counter half-full events and a control-frame event. Each pulse latches into a sticky status flag, and reading the status register clears all flags. The flags are combined with per-event enables, a global enable, a test force and an output-enable bit to drive a registered, active-low interrupt.

Two of the eight flag slots change meaning with a 2-bit slot mode input. Management access arrives as plain register strobes: one cycle of `rd_en` or `wr_en` with `reg_sel` picking the register. `rd_data` is combinational and valid in the cycle of the read. The clear caused by a status read takes effect at the clock edge that ends that cycle. No input carries a data stream, so all pins are plain level or strobe signals with no valid/ready handshake.

Top module: `phy_irq_ctl`

## Requirements
- R1: After reset, all flags, enables and control bits are 0, `irq_n` is 1 and `pin_is_irq` is 0.
- R2: An event pulse sets its flag at the next clock edge whether or not its enable bit is set. The status flag positions are: 15 link quality, 14 energy detect, 13 link change, 12 speed change, 11 duplex change, 10 auto-negotiation complete, 9 slot A and 8 slot B.
- R3: A status read (`reg_sel`=1) returns the flags in bits 15:8 and the enables in bits 7:0. At the end of the read cycle it clears every flag. A control read (`reg_sel`=0) clears nothing.
- R4: An event that pulses in the same cycle as a clearing status read leaves its flag set.
- R5: A status write loads bits 7:0 as enables, where enable bit n gates flag bit n+8. Written bits 15:8 are ignored and do not change the flags.
- R6: Control bit 0 is output enable, bit 1 is global enable and bit 2 is the test force. Bits 15:3 always read 0 and writes to them are ignored.
- R7: `irq_n` is registered. It goes to 0 one edge after output enable and global enable are both 1 and some flag is set together with its enable bit, and it returns to 1 one edge after that condition ends.
- R8: While output enable and the test force are both 1, `irq_n` is 0 from the second edge after the force is written, whatever the flags hold.
- R9: With output enable 0, `irq_n` stays 1 under any flags or force. `pin_is_irq` equals control bit 0.
- R10: With slot mode 00, slot A (bit 9) latches the false-carrier-counter half-full event, slot B (bit 8) latches the receive-error-counter half-full event, and the control-frame event is ignored.
- R11: With either slot mode bit set, slot A latches either counter half-full event and slot B latches the control-frame event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects the control register, 1 the status/enable register |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid while rd_en is 1, otherwise 0 |
| slot_mode | input | 2 | Selects the meaning of slots A and B |
| ev_link_qual | input | 1 | Link quality event pulse |
| ev_energy | input | 1 | Energy detect event pulse |
| ev_link | input | 1 | Link status change pulse |
| ev_speed | input | 1 | Speed change pulse |
| ev_duplex | input | 1 | Duplex change pulse |
| ev_an_done | input | 1 | Auto-negotiation complete pulse |
| ev_fcar_half | input | 1 | False-carrier counter half-full pulse |
| ev_rxerr_half | input | 1 | Receive-error counter half-full pulse |
| ev_ctl_frame | input | 1 | Control-frame event pulse |
| irq_n | output | 1 | Registered active-low interrupt |
| pin_is_irq | output | 1 | 1 when the shared pin is an interrupt output |

## Verification
On every cycle, the assertions check that an event pulse sets its flag, that a status read without a coincident event clears it, and that flags hold between reads. They also check that register writes land, and that `irq_n` follows the output-enable, force and enabled-flag conditions one edge later. Only the bench's scenarios can show the slot remapping under every mode, the read data layout, and reserved control bits reading 0 after an all-ones write. The same applies to end-to-end timing, for example the two-edge delay from an event to the interrupt and the persistence of the force across many cycles.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int EVT_N     = 8;
  localparam int CTRL_BITS = 3;
  localparam int CTRL_OE   = 0;
  localparam int CTRL_GEN  = 1;
  localparam int CTRL_FRC  = 2;
  localparam int MODE_W    = 2;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/phy_irq_slot_map.sv
module phy_irq_slot_map
  import phy_irq_pkg::*;
#(
  parameter int N = EVT_N,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode,
  input  logic          lq,
  input  logic          ed,
  input  logic          lnk,
  input  logic          spd,
  input  logic          dup,
  input  logic          anc,
  input  logic          fc_half,
  input  logic          rx_half,
  input  logic          cf,
  output logic [N-1:0]  evt
);
  logic alt_mode;
  logic slot_a, slot_b;

  assign alt_mode = |mode;

  always_comb begin
    if (alt_mode) begin
      slot_a = fc_half | rx_half;
      slot_b = cf;
    end else begin
      slot_a = fc_half;
      slot_b = rx_half;
    end
  end

  always_comb begin
    evt      = '0;
    evt[N-1] = lq;
    evt[N-2] = ed;
    evt[N-3] = lnk;
    evt[N-4] = spd;
    evt[N-5] = dup;
    evt[N-6] = anc;
    evt[1]   = slot_a;
    evt[0]   = slot_b;
  end

  // R10
  norm_cf_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_mode && !rx_half) |-> !evt[0]);
  // R11
  alt_rx_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_mode && rx_half) |-> evt[1]);
endmodule

// File: rtl/phy_irq_flags.sv
module phy_irq_flags
  import phy_irq_pkg::*;
#(
  parameter int N = EVT_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= (flags[i] & ~clr) | evt[i];
    end

    // R2 R4
    set_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    // R3
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt[i]) |=> !flags[i]);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && flags[i]) |=> flags[i]);
  end
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
  import phy_irq_pkg::*;
#(
  parameter int N  = EVT_N,
  parameter int CB = CTRL_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_stat,
  input  logic [N-1:0]  wdat,
  output logic [CB-1:0] ctrl_q,
  output logic [N-1:0]  en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdat[CB-1:0];
      if (wr_stat) en_q   <= wdat;
    end
  end

  // R6
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == $past(wdat[CB-1:0])));
  // R5
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (en_q == $past(wdat)));
endmodule

// File: rtl/phy_irq_out.sv
module phy_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic oe,
  input  logic gen,
  input  logic frc,
  input  logic pend,
  output logic irq_n
);
  logic want;
  assign want = oe & (frc | (gen & pend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~want;
  end

  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |=> irq_n);
  // R8
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && frc) |=> !irq_n);
  // R7
  event_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && gen && pend) |=> !irq_n);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frc && !(gen && pend)) |=> irq_n);
endmodule

// File: rtl/phy_irq_ctl.sv
module phy_irq_ctl
  import phy_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [MODE_W-1:0] slot_mode,
  input  logic              ev_link_qual,
  input  logic              ev_energy,
  input  logic              ev_link,
  input  logic              ev_speed,
  input  logic              ev_duplex,
  input  logic              ev_an_done,
  input  logic              ev_fcar_half,
  input  logic              ev_rxerr_half,
  input  logic              ev_ctl_frame,
  output logic              irq_n,
  output logic              pin_is_irq
);
  localparam int FLAG_LO = EVT_N;
  localparam int FLAG_HI = 2 * EVT_N - 1;

  logic [EVT_N-1:0]     evt, flags, en_q;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic                 sel_stat, clr, wr_ctrl, wr_stat, pend;
  logic                 unused_wr_hi;

  assign sel_stat     = (reg_sel == SEL_STAT);
  assign clr          = rd_en & sel_stat;
  assign wr_ctrl      = wr_en & ~sel_stat;
  assign wr_stat      = wr_en & sel_stat;
  assign unused_wr_hi = ^wr_data[REG_W-1:EVT_N];

  phy_irq_slot_map #(.N(EVT_N), .MW(MODE_W)) u_map (
    .clk(clk), .rst_n(rst_n), .mode(slot_mode),
    .lq(ev_link_qual), .ed(ev_energy), .lnk(ev_link), .spd(ev_speed),
    .dup(ev_duplex), .anc(ev_an_done), .fc_half(ev_fcar_half),
    .rx_half(ev_rxerr_half), .cf(ev_ctl_frame), .evt(evt)
  );

  phy_irq_flags #(.N(EVT_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .flags(flags)
  );

  phy_irq_regs #(.N(EVT_N), .CB(CTRL_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wdat(wr_data[EVT_N-1:0]), .ctrl_q(ctrl_q), .en_q(en_q)
  );

  assign pend = |(flags & en_q);

  phy_irq_out u_out (
    .clk(clk), .rst_n(rst_n), .oe(ctrl_q[CTRL_OE]), .gen(ctrl_q[CTRL_GEN]),
    .frc(ctrl_q[CTRL_FRC]), .pend(pend), .irq_n(irq_n)
  );

  assign pin_is_irq = ctrl_q[CTRL_OE];

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (sel_stat) begin
        rd_data[EVT_N-1:0]       = en_q;
        rd_data[FLAG_HI:FLAG_LO] = flags;
      end else begin
        rd_data[CTRL_BITS-1:0] = ctrl_q;
      end
    end
  end

  // R6
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_stat) |-> (rd_data[REG_W-1:CTRL_BITS] == '0));
  // R9
  pin_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_is_irq |=> irq_n);
endmodule

// File: tb/phy_irq_ctl_test.sv
`timescale 1ns/1ps
module phy_irq_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  slot_mode = 2'b00;
  logic        ev [9];
  logic        irq_n, pin_is_irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // reference model state
  logic [7:0] m_flags = '0;
  logic [7:0] m_en = '0;
  logic [2:0] m_ctrl = '0;
  logic       m_irq_n = 1'b1;

  always #2 clk = ~clk;

  phy_irq_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .slot_mode(slot_mode),
    .ev_link_qual(ev[0]), .ev_energy(ev[1]), .ev_link(ev[2]), .ev_speed(ev[3]),
    .ev_duplex(ev[4]), .ev_an_done(ev[5]), .ev_fcar_half(ev[6]),
    .ev_rxerr_half(ev[7]), .ev_ctl_frame(ev[8]),
    .irq_n(irq_n), .pin_is_irq(pin_is_irq)
  );

  function automatic logic [7:0] model_events();
    logic [7:0] e;
    e = '0;
    for (int k = 0; k < 6; k++) e[7-k] = ev[k];
    if (slot_mode == 2'b00) begin
      e[1] = ev[6];
      e[0] = ev[7];
    end else begin
      e[1] = ev[6] | ev[7];
      e[0] = ev[8];
    end
    return e;
  endfunction

  always @(posedge clk) begin
    logic nxt_irq;
    logic [7:0] e;
    if (!rst_n) begin
      m_flags = '0; m_en = '0; m_ctrl = '0; m_irq_n = 1'b1;
    end else begin
      nxt_irq = !(m_ctrl[0] && (m_ctrl[2] || (m_ctrl[1] && ((m_flags & m_en) != 0))));
      e = model_events();
      if (rd_en && reg_sel) m_flags = '0;
      m_flags = m_flags | e;
      if (wr_en && reg_sel)  m_en = wr_data[7:0];
      if (wr_en && !reg_sel) m_ctrl = wr_data[2:0];
      m_irq_n = nxt_irq;
    end
  end

  function automatic logic [15:0] model_rd();
    if (!rd_en) return 16'h0000;
    if (reg_sel) return {m_flags, m_en};
    return {13'h0, m_ctrl};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input string tag, input logic [15:0] exp);
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic tick(input string tag);
    #0.5;
    chk({tag, " rd_data"}, rd_data, model_rd());
    chk({tag, " irq_n"}, {15'h0, irq_n}, {15'h0, m_irq_n});
    chk({tag, " pin_is_irq"}, {15'h0, pin_is_irq}, {15'h0, m_ctrl[0]});
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    for (int k = 0; k < 9; k++) ev[k] = 1'b0;
  endtask

  task automatic do_rd(input logic sel);
    reg_sel = sel; rd_en = 1'b1;
  endtask

  task automatic do_wr(input logic sel, input logic [15:0] d);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 9; k++) ev[k] = 1'b0;
    @(negedge clk);
    tick("R1"); tick("R1"); tick("R1");
    rst_n = 1'b1;
    tick("R1");
    do_rd(1'b1); peek("R1 status", 16'h0000); tick("R1");
    do_rd(1'b0); peek("R1 ctrl", 16'h0000); tick("R1");
    chk("R1 irq_n", {15'h0, irq_n}, 16'h0001);
    chk("R1 pin_is_irq", {15'h0, pin_is_irq}, 16'h0000);

    // R2 and R10: each event with enables off, mode 00
    for (int i = 0; i < 8; i++) begin
      ev[i] = 1'b1; tick("R2");
      do_rd(1'b1); peek("R2 flag position", 16'h8000 >> i); tick("R2");
    end
    do_rd(1'b1); peek("R3 cleared", 16'h0000); tick("R3");

    // R5
    do_wr(1'b1, 16'hFFFF); tick("R5");
    do_rd(1'b1); peek("R5 enables only", 16'h00FF); tick("R5");

    // R3
    ev[2] = 1'b1; tick("R3");
    do_rd(1'b0); peek("R3 ctrl read", 16'h0000); tick("R3");
    do_rd(1'b1); peek("R3 link flag kept", 16'h20FF); tick("R3");
    do_rd(1'b1); peek("R3 cleared", 16'h00FF); tick("R3");

    // R4
    ev[3] = 1'b1; do_rd(1'b1); peek("R4 same cycle", 16'h00FF); tick("R4");
    do_rd(1'b1); peek("R4 flag survived", 16'h10FF); tick("R4");

    // R6
    do_wr(1'b0, 16'hFFF8); tick("R6");
    do_rd(1'b0); peek("R6 reserved", 16'h0000); tick("R6");
    do_wr(1'b0, 16'h0003); tick("R6");
    do_rd(1'b0); peek("R6 oe+gen", 16'h0003); tick("R6");

    // R7
    ev[5] = 1'b1; tick("R7");
    chk("R7 irq one edge", {15'h0, irq_n}, 16'h0001);
    tick("R7");
    chk("R7 irq two edges", {15'h0, irq_n}, 16'h0000);
    do_rd(1'b1); tick("R7");
    chk("R7 irq after clear edge", {15'h0, irq_n}, 16'h0000);
    tick("R7");
    chk("R7 irq released", {15'h0, irq_n}, 16'h0001);
    do_wr(1'b1, 16'h0000); tick("R7");
    ev[4] = 1'b1; tick("R7"); tick("R7"); tick("R7");
    chk("R7 masked flag no irq", {15'h0, irq_n}, 16'h0001);
    do_rd(1'b1); peek("R2 flag without enable", 16'h0800); tick("R2");

    // R8
    do_wr(1'b0, 16'h0005); tick("R8"); tick("R8");
    chk("R8 force asserts", {15'h0, irq_n}, 16'h0000);
    for (int i = 0; i < 4; i++) tick("R8");
    chk("R8 force holds", {15'h0, irq_n}, 16'h0000);
    do_wr(1'b0, 16'h0001); tick("R8");
    chk("R8 registered release", {15'h0, irq_n}, 16'h0000);
    tick("R8");
    chk("R8 released", {15'h0, irq_n}, 16'h0001);

    // R9
    do_wr(1'b1, 16'h00FF); tick("R9");
    ev[0] = 1'b1; tick("R9");
    do_wr(1'b0, 16'h0006); tick("R9"); tick("R9"); tick("R9");
    chk("R9 no drive", {15'h0, irq_n}, 16'h0001);
    chk("R9 pin input", {15'h0, pin_is_irq}, 16'h0000);
    do_rd(1'b1); tick("R9");
    do_wr(1'b0, 16'h0000); tick("R9");
    do_wr(1'b1, 16'h0000); tick("R9");

    // R11
    slot_mode = 2'b01;
    ev[7] = 1'b1; tick("R11");
    do_rd(1'b1); peek("R11 rx half to A", 16'h0200); tick("R11");
    ev[8] = 1'b1; tick("R11");
    do_rd(1'b1); peek("R11 ctl frame to B", 16'h0100); tick("R11");
    slot_mode = 2'b10;
    ev[6] = 1'b1; tick("R11");
    do_rd(1'b1); peek("R11 fc half to A", 16'h0200); tick("R11");
    slot_mode = 2'b11;
    ev[7] = 1'b1; ev[8] = 1'b1; tick("R11");
    do_rd(1'b1); peek("R11 both slots", 16'h0300); tick("R11");

    // R10
    slot_mode = 2'b00;
    ev[8] = 1'b1; tick("R10");
    do_rd(1'b1); peek("R10 ctl frame ignored", 16'h0000); tick("R10");
    ev[7] = 1'b1; tick("R10");
    do_rd(1'b1); peek("R10 rx half to B", 16'h0100); tick("R10");
    ev[6] = 1'b1; tick("R10");
    do_rd(1'b1); peek("R10 fc half to A", 16'h0200); tick("R10");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule